// File: doc/BRIEF.md
# Power-Good Strap Capture and Clock Mode Decoder

This block sits beside a clock synthesizer and decides, once per power-up, how the synthesizer should run. Three frequency-select straps and a debug-route strap are held by board resistors. A shared input pin starts out as an active-low power-good strobe. The block synchronizes that pin. On the first clock where the synchronized pin reads low, it latches every strap.

The latched straps are decoded into several results: a 3-bit frequency code, a test-mode flag with its submode (outputs floated, or outputs driven from a divided reference), the select that decides whether the shared differential pair carries the CPU debug clock or a seventh SRC clock, and three readback bits for the register file. After the capture the same pin no longer means power-good. It becomes a level-sensitive, active-high power-down request.

The third frequency strap has three levels. Comparators outside this block turn it into two digital inputs, one for the middle level and one for the high level.

Top module: `strap_capture_top`

## Requirements
- R1: While reset is held and after its release, until the first capture, `captured`=0, `freqCode`=7 (none), `testMode`=0, `testRefDiv`=0, `routeCpu2`=0, `pwrDown`=0 and `fsReadback`=0.
- R2: A low on `pgPin` goes through a two-stage synchronizer. The straps are latched on the third rising edge after the pin goes low, and `captured` becomes 1 at that same edge. After two edges `captured` is still 0.
- R3: Normal decode applies when `fsCMid`=1 and `fsCHigh`=0 at capture. With {fsB,fsA} = 01 the code is 0 (100 MHz CPU), 00 gives 1 (133 MHz), 10 gives 2 (200 MHz) and 11 gives 3 (266 MHz). In all four cases SRC runs at 100 MHz and PCI at 33 MHz.
- R4: If neither `fsCHigh` nor `fsCMid` is set at capture, the code is 6 (reserved). When both are set, `fsCHigh` takes precedence.
- R5: If `fsCHigh`=1 at capture, `testMode`=1. With fsB=0 the code is 4 and `testRefDiv`=0 (outputs floated). With fsB=1 the code is 5 and `testRefDiv`=1 (CPU at REF/2, SRC at REF/8, PCI at REF/24, and the other outputs at REF).
- R6: `routeCpu2` equals the captured ITP-enable strap: 1 routes the shared pair as CPU2, 0 routes it as SRC7.
- R7: Once captured in a mode other than test mode, later changes on the straps and toggles on `pgPin` leave `freqCode`, `routeCpu2` and `fsReadback` unchanged. Only reset clears the capture.
- R8: After a capture outside test mode, `pwrDown` follows the `pgPin` level (active high), delayed by two rising edges.
- R9: In test mode, while the synchronized pin is low, fsB is sampled again on every edge, so the submode (code 4 or 5, `testRefDiv`, `fsReadback[1]`) follows it one edge later. In test mode `pwrDown` stays 0.
- R10: `fsReadback` is {FS_C high, fsB, fsA} as captured, with bit 2 being the high-level FS_C flag and bit 0 being fsA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pgPin | input | 1 | Shared pin: power-good (low) before capture, power-down (high) after |
| fsA | input | 1 | Frequency strap A |
| fsB | input | 1 | Frequency strap B |
| fsCMid | input | 1 | Strap C seen at the middle level |
| fsCHigh | input | 1 | Strap C seen at the high level |
| itpEn | input | 1 | Debug-route strap |
| captured | output | 1 | Straps have been latched |
| freqCode | output | 3 | Decoded frequency/test code |
| testMode | output | 1 | Test mode active |
| testRefDiv | output | 1 | Test submode: 1 divided reference, 0 floated |
| routeCpu2 | output | 1 | 1 = CPU2 route, 0 = SRC7 route |
| pwrDown | output | 1 | Power-down request level |
| fsReadback | output | 3 | {FS_C high, FS_B, FS_A} for register readback |

## Verification
The assertions assume that the straps do not move in the clock where the synchronized strobe first reads low, and that reset is the only way to re-arm the capture. The stimulus meets both assumptions. It changes straps and the pin only on falling clock edges. It starts each random trial from a fresh reset. It picks strap values with a fixed-seed random generator, then adds directed trials that reach every normal code, both test submodes and the reserved level.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    FREQ_100    = 3'd0,
    FREQ_133    = 3'd1,
    FREQ_200    = 3'd2,
    FREQ_266    = 3'd3,
    TEST_HIZ    = 3'd4,
    TEST_REFDIV = 3'd5,
    FREQ_RSVD   = 3'd6,
    FREQ_NONE   = 3'd7
  } freqCode_e;

  typedef struct packed {
    logic captureStb;   // load every strap this edge
    logic resampleStb;  // test mode: reload FS_B only
  } strapCtrl_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pgPin,
  input  logic       testMode,
  output strapCtrl_t ctrl,
  output logic       captured,
  output logic       pwrDown
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic pinSync;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[i] <= 1'b1;
        else if (i == 0) syncChain[i] <= pgPin;
        else syncChain[i] <= syncChain[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign pinSync = syncChain[SYNC_STAGES-1];

  always_comb begin
    ctrl.captureStb  = !captured && !pinSync;
    ctrl.resampleStb = captured && testMode && !pinSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) captured <= 1'b0;
    else if (ctrl.captureStb) captured <= 1'b1;
  end

  assign pwrDown = captured && !testMode && pinSync;

  // R7
  sticky_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    captured |=> captured);
  // R2
  capture_on_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(captured) |-> !$past(pinSync));
  // R7
  single_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    captured |-> !ctrl.captureStb);
  // R9
  no_pd_in_test_chk: assert property (@(posedge clk) disable iff (!rstN)
    testMode |-> !pwrDown);
endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strapCtrl_t        ctrl,
  input  logic              captured,
  input  logic              fsA,
  input  logic              fsB,
  input  logic              fsCMid,
  input  logic              fsCHigh,
  input  logic              itpEn,
  output logic [CODE_W-1:0] freqCode,
  output logic              testMode,
  output logic              testRefDiv,
  output logic              routeCpu2,
  output logic [2:0]        fsReadback
);
  logic aReg, bReg, cMidReg, cHighReg, itpReg;
  freqCode_e codeNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {aReg, bReg, cMidReg, cHighReg, itpReg} <= '0;
    end else if (ctrl.captureStb) begin
      aReg     <= fsA;
      bReg     <= fsB;
      cMidReg  <= fsCMid;
      cHighReg <= fsCHigh;
      itpReg   <= itpEn;
    end else if (ctrl.resampleStb) begin
      bReg <= fsB;
    end
  end

  always_comb begin
    if (!captured)      codeNext = FREQ_NONE;
    else if (cHighReg)  codeNext = bReg ? TEST_REFDIV : TEST_HIZ;
    else if (cMidReg) begin
      unique case ({bReg, aReg})
        2'b01:   codeNext = FREQ_100;
        2'b00:   codeNext = FREQ_133;
        2'b10:   codeNext = FREQ_200;
        default: codeNext = FREQ_266;
      endcase
    end else            codeNext = FREQ_RSVD;
  end

  assign freqCode   = codeNext;
  assign testMode   = captured && cHighReg;
  assign testRefDiv = testMode && bReg;
  assign routeCpu2  = itpReg;
  assign fsReadback = {cHighReg, bReg, aReg};

  // R7
  frozen_normal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (captured && !testMode) |=> ($stable(fsReadback) && $stable(freqCode)));
  // R6
  route_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    captured |=> $stable(routeCpu2));
  // R9
  test_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    testMode |=> testMode);
endmodule

// File: rtl/strap_capture_top.sv
module strap_capture_top
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pgPin,
  input  logic       fsA,
  input  logic       fsB,
  input  logic       fsCMid,
  input  logic       fsCHigh,
  input  logic       itpEn,
  output logic       captured,
  output logic [2:0] freqCode,
  output logic       testMode,
  output logic       testRefDiv,
  output logic       routeCpu2,
  output logic       pwrDown,
  output logic [2:0] fsReadback
);
  strapCtrl_t ctrl;

  strap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pgPin(pgPin), .testMode(testMode),
    .ctrl(ctrl), .captured(captured), .pwrDown(pwrDown)
  );

  strap_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .captured(captured),
    .fsA(fsA), .fsB(fsB), .fsCMid(fsCMid), .fsCHigh(fsCHigh), .itpEn(itpEn),
    .freqCode(freqCode), .testMode(testMode), .testRefDiv(testRefDiv),
    .routeCpu2(routeCpu2), .fsReadback(fsReadback)
  );
endmodule

// File: tb/strap_capture_top_bench.sv
module strap_capture_top_bench;
  logic clk = 1'b0;
  logic rstN, pgPin, fsA, fsB, fsCMid, fsCHigh, itpEn;
  logic captured, testMode, testRefDiv, routeCpu2, pwrDown;
  logic [2:0] freqCode, fsReadback;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strap_capture_top u_strap_capture_top (
    .clk(clk), .rstN(rstN), .pgPin(pgPin), .fsA(fsA), .fsB(fsB),
    .fsCMid(fsCMid), .fsCHigh(fsCHigh), .itpEn(itpEn), .captured(captured),
    .freqCode(freqCode), .testMode(testMode), .testRefDiv(testRefDiv),
    .routeCpu2(routeCpu2), .pwrDown(pwrDown), .fsReadback(fsReadback)
  );

  function automatic logic [2:0] expCode(logic ch, logic cm, logic b, logic a);
    if (ch) return b ? 3'd5 : 3'd4;
    if (!cm) return 3'd6;
    case ({b, a})
      2'b01:   return 3'd0;
      2'b00:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trial(logic ch, logic cm, logic b, logic a, logic itp);
    logic [2:0] code, rb;
    rstN = 1'b0; pgPin = 1'b1;
    fsCHigh = ch; fsCMid = cm; fsB = b; fsA = a; itpEn = itp;
    tick(2);
    // R1 reset state
    chk("R1", {captured, freqCode, testMode, pwrDown, routeCpu2, testRefDiv}, 8'b0_111_0000);
    chk("R1", {5'b0, fsReadback}, 8'h0);
    rstN = 1'b1;
    tick(3);
    chk("R1", {7'b0, captured}, 8'h0);
    pgPin = 1'b0;
    tick(2);
    // R2 not yet captured after two edges
    chk("R2", {7'b0, captured}, 8'h0);
    tick(1);
    chk("R2", {7'b0, captured}, 8'h1);
    code = expCode(ch, cm, b, a);
    // R3 R4 R5 decode
    chk(ch ? "R5" : (cm ? "R3" : "R4"), {5'b0, freqCode}, {5'b0, code});
    chk("R5", {6'b0, testMode, testRefDiv}, {6'b0, ch, ch & b});
    chk("R6", {7'b0, routeCpu2}, {7'b0, itp});
    rb = {ch, b, a};
    chk("R10", {5'b0, fsReadback}, {5'b0, rb});
    if (!ch) begin
      fsA = ~a; fsB = ~b; fsCMid = ~cm; fsCHigh = 1'b1; itpEn = ~itp;
      pgPin = 1'b1;
      tick(1);
      chk("R8", {7'b0, pwrDown}, 8'h0);
      tick(1);
      chk("R8", {7'b0, pwrDown}, 8'h1);
      pgPin = 1'b0;
      tick(2);
      chk("R8", {7'b0, pwrDown}, 8'h0);
      tick(3);
      // R7 one-shot: nothing re-captured
      chk("R7", {5'b0, freqCode}, {5'b0, code});
      chk("R7", {4'b0, routeCpu2, fsReadback}, {4'b0, itp, rb});
    end else begin
      fsB = ~b; fsA = ~a; itpEn = ~itp;
      tick(1);
      // R9 FS_B live in test mode
      chk("R9", {5'b0, freqCode}, {5'b0, expCode(1'b1, cm, ~b, a)});
      chk("R9", {6'b0, testRefDiv, fsReadback[1]}, {6'b0, ~b, ~b});
      chk("R9", {6'b0, fsReadback[0], routeCpu2}, {6'b0, a, itp});
      pgPin = 1'b1;
      tick(3);
      chk("R9", {7'b0, pwrDown}, 8'h0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // directed: every normal code, both test submodes, reserved, precedence
    trial(0, 1, 0, 1, 0);
    trial(0, 1, 0, 0, 1);
    trial(0, 1, 1, 0, 0);
    trial(0, 1, 1, 1, 1);
    trial(1, 0, 0, 0, 1);
    trial(1, 0, 1, 1, 0);
    trial(1, 1, 0, 1, 0);
    trial(0, 0, 1, 0, 1);
    for (int i = 0; i < 40; i++) begin
      logic [4:0] r;
      r = 5'($urandom);
      trial(r[4], r[3], r[2], r[1], r[0]);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule